// File: doc/BRIEF.md
# Interleaved Block Memory

A main-memory model built from several one-word-wide banks that fill whole cache blocks. Consecutive word addresses fall in consecutive banks: the low address bits choose the bank and the remaining bits choose the row inside that bank. A block request carries a base word address and a length of one, two or four words. Only requests whose base address is aligned to the block length are legal.

When a request is accepted, the block spends a fixed address phase. It then starts every bank that the block covers in the same cycle, so all of those banks run their access latency in parallel. After that, words move one at a time over a one-word bus, each in a fixed-length transfer slot. A block of n words therefore occupies the subsystem for one address time, plus one access time, plus n transfer slots. A word-serial memory would instead pay the whole cost once for every word.

Reads return their words in increasing address order, with a one-cycle strobe at the end of each transfer slot. A write carries the whole block's data with the request and runs to the same schedule. A misaligned or illegal request is refused with an error pulse and nothing is done.

Top module: `ilv_mem`

## Requirements
- R1: After reset, busy_o, rd_valid_o, done_o and err_o are all low.
- R2: Word address a is stored in bank a mod NUM_BANKS, at row a / NUM_BANKS. A word written at any address reads back unchanged from that address, whatever block length is used to write it or read it.
- R3: req_len_i selects the block length: 0 means 1 word, 1 means 2 words, 2 means 4 words. A legal request is accepted in a cycle where req_valid_i is high and busy_o is low. With the defaults (address 4, access 24, transfer 4 cycles), busy_o is then high for exactly 28 + 4n cycles, which is 32, 36 or 44 cycles.
- R4: On a read, word k of the block (address base + k) appears on rd_data_o while rd_valid_o is high for one cycle. Counting the first busy cycle as cycle 0, this is cycle 31 + 4k. Words come out in increasing address order, and rd_valid_o is never high in two adjacent cycles.
- R5: On a write, word k of req_wdata_i (bits k*DATA_W and up) is stored at address base + k. rd_valid_o stays low for the whole write, and the write keeps the same busy duration as a read of the same length.
- R6: Every bank covered by a block completes its access in the same cycle. No other bank is active.
- R7: A request whose base address is not a multiple of its length, or whose length code is 3, produces a one-cycle err_o pulse in the cycle after it is presented. busy_o stays low and memory is unchanged.
- R8: req_valid_i is ignored while busy_o is high. It neither starts a block nor raises err_o.
- R9: done_o is high for exactly one cycle, the last busy cycle. busy_o falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Block request present |
| req_we_i | input | 1 | 1 = write block, 0 = read block |
| req_addr_i | input | ADDR_W | Block base word address |
| req_len_i | input | 2 | Length code: 0 = 1 word, 1 = 2 words, 2 = 4 words |
| req_wdata_i | input | NUM_BANKS*DATA_W | Write words; word k sits in bits [k*DATA_W +: DATA_W] |
| busy_o | output | 1 | Block in progress |
| err_o | output | 1 | Request refused (misaligned or illegal length) |
| rd_valid_o | output | 1 | Read word strobe |
| rd_data_o | output | DATA_W | Read word |
| done_o | output | 1 | Final cycle of a block |

## Verification
The bench builds the block with ADDR_W = 8, which gives 64 rows per bank, and keeps the default timing of 4/24/4 cycles. With the memory this small, the bench can fill every address first and then compare every returned word against a fully known image. Random aligned reads and writes of all three lengths land in every bank and every row. The bench also tries misaligned bases, the illegal length code, and requests raised mid-block, and it checks the exact strobe and done cycles against a counting model on every clock.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_ACC, ST_XFER} ilv_st_e;
  localparam int LEN_W = 2;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DATA_W  = 32,
  parameter int ROW_W   = 6,
  parameter int ACC_CYC = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ROW_W;
  localparam int CNT_W = $clog2(ACC_CYC + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              busy_q, we_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ROW_W-1:0]  row_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign ack_o   = busy_q && (cnt_q == CNT_W'(ACC_CYC - 1));
  assign rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (ack_o) busy_q <= 1'b0;
        else       cnt_q  <= cnt_q + 1'b1;
      end
      if (ack_o && !we_q) rdata_q <= mem_q[row_q];
    end
  end

  always_ff @(posedge clk_i) begin
    if (start_i) begin
      we_q    <= we_i;
      row_q   <= row_i;
      wdata_q <= wdata_i;
    end
    if (ack_o && we_q) mem_q[row_q] <= wdata_q;
  end
endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 10,
  parameter int ADDR_CYC  = 4,
  parameter int XFER_CYC  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic                       req_we_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [LEN_W-1:0]           req_len_i,
  input  logic                       acc_done_i,
  output logic                       busy_o,
  output logic                       err_o,
  output logic                       accept_o,
  output logic                       bank_start_o,
  output logic                       we_o,
  output logic [ADDR_W-1:0]          base_o,
  output logic [NUM_BANKS-1:0]       sel_mask_o,
  output logic [$clog2(NUM_BANKS)-1:0] word_o,
  output logic                       rd_valid_o,
  output logic                       done_o
);
  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int MAX_LEN = BANK_W;
  localparam int CYC_MAX = (ADDR_CYC > XFER_CYC) ? ADDR_CYC : XFER_CYC;
  localparam int CNT_W   = $clog2(CYC_MAX + 1);

  ilv_st_e            st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BANK_W-1:0]  word_q;
  logic [BANK_W:0]    nwords_q, req_words;
  logic [BANK_W-1:0]  align_mask, base_bank;
  logic               we_q, err_q, legal, slot_end, last_word;
  logic [ADDR_W-1:0]  base_q;

  assign req_words  = (BANK_W+1)'(1) << req_len_i;
  assign align_mask = req_words[BANK_W-1:0] - 1'b1;
  assign legal      = (int'(req_len_i) <= MAX_LEN) &&
                      ((req_addr_i[BANK_W-1:0] & align_mask) == '0);
  assign accept_o   = req_valid_i && (st_q == ST_IDLE);
  assign slot_end   = (st_q == ST_XFER) && (cnt_q == CNT_W'(XFER_CYC - 1));
  assign last_word  = ({1'b0, word_q} == nwords_q - 1'b1);
  assign base_bank  = base_q[BANK_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      word_q   <= '0;
      nwords_q <= '0;
      we_q     <= 1'b0;
      err_q    <= 1'b0;
      base_q   <= '0;
    end else begin
      err_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept_o) begin
          if (legal) begin
            st_q     <= ST_ADDR;
            cnt_q    <= '0;
            we_q     <= req_we_i;
            base_q   <= req_addr_i;
            nwords_q <= req_words;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_ADDR: begin
          if (cnt_q == CNT_W'(ADDR_CYC - 1)) begin
            st_q  <= ST_ACC;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ACC: if (acc_done_i) begin
          st_q   <= ST_XFER;
          cnt_q  <= '0;
          word_q <= '0;
        end
        ST_XFER: begin
          if (slot_end) begin
            cnt_q <= '0;
            if (last_word) st_q   <= ST_IDLE;
            else           word_q <= word_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      sel_mask_o[b] = (BANK_W+1)'(b) >= {1'b0, base_bank} &&
                      (BANK_W+1)'(b) <  ({1'b0, base_bank} + nwords_q);
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign err_o        = err_q;
  assign bank_start_o = (st_q == ST_ADDR) && (cnt_q == CNT_W'(ADDR_CYC - 1));
  assign we_o         = we_q;
  assign base_o       = base_q;
  assign word_o       = word_q;
  assign rd_valid_o   = slot_end && !we_q;
  assign done_o       = slot_end && last_word;
endmodule

// File: rtl/ilv_mem.sv
module ilv_mem
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 10,
  parameter int ADDR_CYC  = 4,
  parameter int ACC_CYC   = 24,
  parameter int XFER_CYC  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic                        req_we_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [1:0]                  req_len_i,
  input  logic [NUM_BANKS*DATA_W-1:0] req_wdata_i,
  output logic                        busy_o,
  output logic                        err_o,
  output logic                        rd_valid_o,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic                        done_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;

  logic                        accept, bank_start, we;
  logic [ADDR_W-1:0]           base;
  logic [NUM_BANKS-1:0]        sel_mask, bank_ack;
  logic [BANK_W-1:0]           word_idx, rd_bank;
  logic [NUM_BANKS*DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0]           bank_rdata [NUM_BANKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wdata_q <= '0;
    else if (accept) wdata_q <= req_wdata_i;
  end

  ilv_ctrl #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W),
    .ADDR_CYC(ADDR_CYC), .XFER_CYC(XFER_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_we_i, .req_addr_i,
    .req_len_i    (req_len_i),
    .acc_done_i   (|bank_ack),
    .busy_o, .err_o,
    .accept_o     (accept),
    .bank_start_o (bank_start),
    .we_o         (we),
    .base_o       (base),
    .sel_mask_o   (sel_mask),
    .word_o       (word_idx),
    .rd_valid_o, .done_o
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] lane;
    assign lane = BANK_W'(b) - base[BANK_W-1:0];
    ilv_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W), .ACC_CYC(ACC_CYC)) u_bank (
      .clk_i, .rst_ni,
      .start_i (bank_start && sel_mask[b]),
      .we_i    (we),
      .row_i   (base[ADDR_W-1:BANK_W]),
      .wdata_i (wdata_q[lane*DATA_W +: DATA_W]),
      .ack_o   (bank_ack[b]),
      .rdata_o (bank_rdata[b])
    );
  end

  assign rd_bank   = base[BANK_W-1:0] + word_idx;
  assign rd_data_o = bank_rdata[rd_bank];
endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 busy_o,
  input logic                 err_o,
  input logic                 rd_valid_o,
  input logic                 done_o,
  input logic [NUM_BANKS-1:0] bank_ack,
  input logic [NUM_BANKS-1:0] sel_mask
);
  AST_ACK_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bank_ack) |-> (bank_ack == sel_mask)); // R6
  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o); // R7
  AST_BUSY_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_valid_i) |=> !err_o); // R8
  AST_START_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i)); // R3
  AST_VALID_IN_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> busy_o); // R4
  AST_VALID_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R4
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R9
endmodule

bind ilv_mem ilv_mem_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .busy_o, .err_o, .rd_valid_o, .done_o,
  .bank_ack (bank_ack),
  .sel_mask (sel_mask)
);

// File: tb/ilv_mem_tb.sv
module ilv_mem_tb;
  localparam int NB = 4, DW = 32, AW = 8;
  localparam int T_ADDR = 4, T_ACC = 24, T_XFER = 4;
  localparam int WORDS = 1 << AW;

  logic            clk_i = 1'b0, rst_ni = 1'b0;
  logic            req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [AW-1:0]   req_addr_i = '0;
  logic [1:0]      req_len_i = '0;
  logic [NB*DW-1:0] req_wdata_i = '0;
  logic            busy_o, err_o, rd_valid_o, done_o;
  logic [DW-1:0]   rd_data_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk_i = ~clk_i;

  ilv_mem #(.NUM_BANKS(NB), .DATA_W(DW), .ADDR_W(AW),
            .ADDR_CYC(T_ADDR), .ACC_CYC(T_ACC), .XFER_CYC(T_XFER)) u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_we_i, .req_addr_i, .req_len_i,
    .req_wdata_i, .busy_o, .err_o, .rd_valid_o, .rd_data_o, .done_o);

  // reference model
  logic [DW-1:0] mem_m [WORDS];
  logic [DW-1:0] m_words [NB];
  bit m_busy, m_we, e_err, e_valid, e_done;
  int m_cyc, m_tot;
  logic [DW-1:0] e_data;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; e_err = 0; e_valid = 0; e_done = 0; m_cyc = 0; m_tot = 0;
    end else begin
      e_err = 0;
      if (m_busy) begin
        m_cyc++;
        if (m_cyc == m_tot) m_busy = 0;
      end else if (req_valid_i) begin
        int n;
        n = 1 << req_len_i;
        if (req_len_i > 2 || (int'(req_addr_i) % n) != 0) e_err = 1;
        else begin
          m_busy = 1; m_cyc = 0; m_we = req_we_i;
          m_tot = T_ADDR + T_ACC + T_XFER * n;
          for (int k = 0; k < n; k++) begin
            if (m_we) mem_m[int'(req_addr_i) + k] = req_wdata_i[k*DW +: DW];
            m_words[k] = mem_m[int'(req_addr_i) + k];
          end
        end
      end
      e_valid = 0; e_done = 0;
      if (m_busy) begin
        e_done = (m_cyc == m_tot - 1);
        if (!m_we && m_cyc >= T_ADDR + T_ACC + T_XFER - 1 &&
            (m_cyc - (T_ADDR + T_ACC + T_XFER - 1)) % T_XFER == 0) begin
          e_valid = 1;
          e_data  = m_words[(m_cyc - (T_ADDR + T_ACC + T_XFER - 1)) / T_XFER];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk_i) if (rst_ni) begin
    cyc++;
    chk(busy_o == m_busy, "R3 busy", busy_o, m_busy);
    chk(err_o == e_err, "R7 err", err_o, e_err);
    chk(done_o == e_done, "R9 done", done_o, e_done);
    chk(rd_valid_o == e_valid, m_we ? "R5 rd_valid in write" : "R4 rd_valid", rd_valid_o, e_valid);
    if (e_valid && rd_valid_o) chk(rd_data_o == e_data, "R2 R4 rd_data", rd_data_o, e_data);
  end

  task automatic issue(input bit we, input int addr, input int len, input logic [NB*DW-1:0] wd);
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = AW'(addr);
    req_len_i = 2'(len); req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (busy_o) @(negedge clk_i);
  endtask

  function automatic logic [NB*DW-1:0] pat(input int base, input int salt);
    logic [NB*DW-1:0] v;
    for (int k = 0; k < NB; k++) v[k*DW +: DW] = DW'((base + k) * 32'h01010101) ^ DW'(salt);
    return v;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    chk(busy_o == 0 && rd_valid_o == 0 && done_o == 0 && err_o == 0, "R1 reset outputs",
        {busy_o, rd_valid_o, done_o, err_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(busy_o == 0 && err_o == 0, "R1 after reset", {busy_o, err_o}, 0);

    // R2 R5: fill memory with 4-word writes
    for (int a = 0; a < WORDS; a += 4) issue(1, a, 2, pat(a, 32'hA5000000));
    // R3 R4: reads of every length
    issue(0, 8, 2, '0);
    issue(0, 13, 0, '0);
    issue(0, 6, 1, '0);
    issue(0, 252, 2, '0);
    // R5: 1- and 2-word writes, then readback via other lengths (R2)
    issue(1, 9, 0, pat(900, 32'h5A5A0000));
    issue(1, 10, 1, pat(77, 32'h00FF00FF));
    issue(0, 8, 2, '0);
    issue(0, 11, 0, '0);
    // R7: misaligned and illegal length
    issue(0, 2, 2, '0);
    issue(1, 5, 1, pat(1, 1));
    issue(0, 4, 3, '0);
    issue(0, 4, 2, '0);
    // R8: request during busy is ignored
    @(negedge clk_i);
    req_valid_i = 1'b1; req_we_i = 1'b0; req_addr_i = 8'd16; req_len_i = 2'd1;
    @(negedge clk_i);
    req_we_i = 1'b1; req_addr_i = 8'd20; req_len_i = 2'd2; req_wdata_i = pat(5, 32'hDEAD0000);
    repeat (5) @(negedge clk_i);
    req_addr_i = 8'd3; req_len_i = 2'd1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    issue(0, 20, 2, '0);
    // random mix
    for (int i = 0; i < 60; i++) begin
      int len, addr;
      len  = int'($urandom_range(0, 2));
      addr = int'($urandom_range(0, WORDS - 1)) & ~((1 << len) - 1);
      issue(($urandom_range(0, 2) == 0), addr, len, pat(addr + i, int'($urandom)));
    end
    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule